// File: doc/BRIEF.md
# Dual-Lane Receive Packet Driver

This block sits on the PHY side of a parallel PHY-to-link interface. It forwards one received bus packet at a time toward the link. It drives a 2-bit control bus, a low byte lane, a high byte lane and a strobe that marks when the high lane carries real packet data. An upstream packet source supplies two things. The first is a header, which gives the packet speed, a legacy/beta format flag and an optional status byte. The second is a stream of packet beats. The block produces the data-on indication, the optional status cycle, the speed-code cycle and the packet bytes, followed by one idle cycle. It then returns to rest.

At the top speed (S3200) the block packs two packet bytes into each clock. Every control cycle is widened with a zero upper byte. At S1600 and below only the low lane is used, and each byte is repeated for as many clocks as its speed needs.

Separate output-enable signals model the tri-state behaviour, so the block stays synthesizable. One enable covers the control bus and the low lane. A second enable covers the high lane and its strobe.

Both inputs use valid/ready handshakes, with the following rules:
- A header is taken on a clock where `hdr_valid` and `hdr_ready` are both high.
- `hdr_ready` is high only while the block is at rest and the link does not own the bus.
- A beat is taken on a clock where `in_ready` is high. `in_ready` rises exactly on the clock in which the next beat is consumed.
- The source must already hold `in_valid` high whenever `in_ready` is high, so the packet never stalls on the wire.
- If `in_valid` is missing at that point, the packet is cut short and the block goes to the trailing idle cycle.

Top module: `rx_lane_driver`

## Requirements
- R1: After reset, and at rest, the block drives ctl=00 and low lane=00 with `lo_oe`=1, keeps `hi_oe`=0, and raises `hdr_ready`.
- R2: The clock after a header handshake, the outputs begin this sequence:
  - data-on (ctl=10, low=FFh);
  - if a status byte is present, a status cycle and then a second data-on;
  - the speed-code cycle (ctl=10);
  - the packet byte cycles (ctl=10);
  - exactly one idle cycle (ctl=00, low=00).

  After that the block is back at rest.
- R3: The speed-code byte depends on `hdr_speed` (0=S100, 1=S200, 2=S400, 3=S800, 4=S1600, 5=S3200) and on `hdr_legacy`:
  - S100: legacy 00h, beta 01h;
  - S200: legacy 04h, beta 05h;
  - S400: legacy 08h, beta 09h;
  - S800: 0Dh;
  - S1600: 0Fh;
  - S3200: 0Bh.

  `hdr_legacy` is ignored at S800 and above.
- R4: On the low lane, each packet byte is held for 16 clocks at S100, 8 at S200, 4 at S400, 2 at S800 and 1 at S1600.
- R5: At S3200, each beat with `in_pair`=1 occupies one clock. `in_data[7:0]` goes on the low lane, `in_data[15:8]` goes on the high lane, and the high-lane strobe is 1.
- R6: At S3200, `hi_oe` is 1 from the first data-on cycle through the trailing idle cycle. Every non-data cycle in that span drives high lane=00 with the strobe at 0.
- R7: At S3200, a final beat with `in_pair`=0 drives its byte on the low lane, 00 on the high lane, and 0 on the strobe.
- R8: At S1600 and below, `hi_oe` stays 0 for the whole sequence, and `in_pair` and `in_data[15:8]` have no effect.
- R9: While `link_owns` is high at rest, `lo_oe`=0, `hi_oe`=0 and `hdr_ready`=0, and a pending header is not started.
- R10: `hdr_ready` is 0 from the clock after a header handshake until the block is back at rest. The source must hold `in_valid` high whenever `in_ready` is high.
- R11: When `hdr_has_stat`=1, the status cycle drives ctl=01 with `hdr_stat` on the low lane. When `hdr_has_stat`=0, no ctl=01 cycle appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_owns | input | 1 | Link holds the bus; release both lanes while at rest |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header accepted this clock if valid |
| hdr_speed | input | 3 | Packet speed index (0=S100 … 5=S3200) |
| hdr_legacy | input | 1 | Legacy format flag (used at S100–S400 only) |
| hdr_has_stat | input | 1 | Emit a status cycle |
| hdr_stat | input | 8 | Status byte |
| in_valid | input | 1 | Packet beat offered |
| in_ready | output | 1 | Beat consumed this clock |
| in_data | input | 16 | Beat bytes; [7:0] first, [15:8] second |
| in_pair | input | 1 | Beat carries two bytes (S3200 only) |
| in_last | input | 1 | Final beat of the packet |
| ctl_o | output | 2 | Control bus |
| lo_o | output | 8 | Low byte lane |
| lo_oe | output | 1 | Enable for control bus and low lane |
| hi_o | output | 8 | High byte lane |
| hi_oe | output | 1 | Enable for high lane and its strobe |
| hv_o | output | 1 | High-lane data strobe |

## Verification
The ports reveal a wrong internal phase or slot count within one clock. A misplaced phase shows up as:
- a control code out of order;
- a missing or extra status or data-on cycle;
- a trailing idle that starts too early or too late.

A wrong repeat count shifts every following byte boundary, so the mismatch appears at the first byte change. A wrong speed latch shows up on the very first data-on cycle. At that point the high-lane enable is wrongly set for a narrow speed, or wrongly clear for S3200. A stale pair or last flag shows up as a strobe at 1 on an odd final beat, or as a packet that runs past its last beat.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int LANE_W       = 8;
  localparam int BEAT_W       = 2 * LANE_W;
  localparam int REP_LOG2_MAX = 4;

  typedef enum logic [2:0] {
    SPD_S100  = 3'd0,
    SPD_S200  = 3'd1,
    SPD_S400  = 3'd2,
    SPD_S800  = 3'd3,
    SPD_S1600 = 3'd4,
    SPD_S3200 = 3'd5
  } speed_e;

  typedef enum logic [2:0] {
    PH_REST, PH_DON1, PH_STAT, PH_DON2, PH_CODE, PH_DATA, PH_TAIL
  } phase_e;

  localparam logic [LANE_W-1:0] DATA_ON_BYTE = 8'hFF;

  function automatic logic [LANE_W-1:0] speed_code(speed_e s, logic legacy);
    case (s)
      SPD_S100:  return legacy ? 8'h00 : 8'h01;
      SPD_S200:  return legacy ? 8'h04 : 8'h05;
      SPD_S400:  return legacy ? 8'h08 : 8'h09;
      SPD_S800:  return 8'h0D;
      SPD_S1600: return 8'h0F;
      default:   return 8'h0B;
    endcase
  endfunction

  // clocks each byte occupies on the low lane
  function automatic logic [REP_LOG2_MAX:0] speed_reps(speed_e s);
    case (s)
      SPD_S100: return 5'd16;
      SPD_S200: return 5'd8;
      SPD_S400: return 5'd4;
      SPD_S800: return 5'd2;
      default:  return 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/rxd_seq.sv
module rxd_seq
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_owns,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  speed_e            hdr_speed,
  input  logic              hdr_legacy,
  input  logic              hdr_has_stat,
  input  logic [LANE_W-1:0] hdr_stat,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              in_pair,
  input  logic              in_last,
  output phase_e            phase,
  output speed_e            cur_speed,
  output logic              cur_legacy,
  output logic [LANE_W-1:0] cur_stat,
  output logic [LANE_W-1:0] cur_lo,
  output logic [LANE_W-1:0] cur_hi,
  output logic              cur_pair
);
  logic                    has_stat_q;
  logic                    last_q;
  logic [REP_LOG2_MAX-1:0] cnt_q;
  logic [REP_LOG2_MAX:0]   reps;
  logic                    slot_end;
  logic                    hdr_fire;
  logic                    wide;

  assign reps      = speed_reps(cur_speed);
  assign slot_end  = ({1'b0, cnt_q} == reps - 1'b1);
  assign wide      = (cur_speed == SPD_S3200);
  assign hdr_ready = (phase == PH_REST) && !link_owns;
  assign hdr_fire  = hdr_valid && hdr_ready;
  assign in_ready  = (phase == PH_CODE) ||
                     ((phase == PH_DATA) && slot_end && !last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_REST;
      cur_speed  <= SPD_S100;
      cur_legacy <= 1'b0;
      cur_stat   <= '0;
      has_stat_q <= 1'b0;
      cur_lo     <= '0;
      cur_hi     <= '0;
      cur_pair   <= 1'b0;
      last_q     <= 1'b0;
      cnt_q      <= '0;
    end else begin
      case (phase)
        PH_REST: if (hdr_fire) begin
          cur_speed  <= hdr_speed;
          cur_legacy <= hdr_legacy;
          cur_stat   <= hdr_stat;
          has_stat_q <= hdr_has_stat;
          phase      <= PH_DON1;
        end
        PH_DON1: phase <= has_stat_q ? PH_STAT : PH_CODE;
        PH_STAT: phase <= PH_DON2;
        PH_DON2: phase <= PH_CODE;
        PH_CODE, PH_DATA: begin
          if (phase == PH_DATA && !slot_end) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (in_ready && in_valid) begin
            cur_lo   <= in_data[LANE_W-1:0];
            cur_pair <= in_pair && wide;
            cur_hi   <= (in_pair && wide) ? in_data[BEAT_W-1:LANE_W] : '0;
            last_q   <= in_last;
            cnt_q    <= '0;
            phase    <= PH_DATA;
          end else begin
            phase <= PH_TAIL;
          end
        end
        default: phase <= PH_REST;
      endcase
    end
  end

  // R10
  src_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

  // R10
  hdr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |=> !hdr_ready);
endmodule

// File: rtl/rxd_fmt.sv
module rxd_fmt
  import rxd_pkg::*;
(
  input  phase_e            phase,
  input  speed_e            cur_speed,
  input  logic              cur_legacy,
  input  logic [LANE_W-1:0] cur_stat,
  input  logic [LANE_W-1:0] cur_lo,
  input  logic [LANE_W-1:0] cur_hi,
  input  logic              cur_pair,
  input  logic              link_owns,
  output logic [1:0]        ctl_o,
  output logic [LANE_W-1:0] lo_o,
  output logic              lo_oe,
  output logic [LANE_W-1:0] hi_o,
  output logic              hi_oe,
  output logic              hv_o
);
  logic wide;
  assign wide = (cur_speed == SPD_S3200);

  always_comb begin
    ctl_o = 2'b00;
    lo_o  = '0;
    hi_o  = '0;
    hv_o  = 1'b0;
    lo_oe = !((phase == PH_REST) && link_owns);
    hi_oe = wide && (phase != PH_REST);
    case (phase)
      PH_DON1, PH_DON2: begin ctl_o = 2'b10; lo_o = DATA_ON_BYTE; end
      PH_STAT:          begin ctl_o = 2'b01; lo_o = cur_stat; end
      PH_CODE:          begin ctl_o = 2'b10; lo_o = speed_code(cur_speed, cur_legacy); end
      PH_DATA: begin
        ctl_o = 2'b10;
        lo_o  = cur_lo;
        hi_o  = cur_hi;
        hv_o  = cur_pair;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rx_lane_driver.sv
module rx_lane_driver
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_owns,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [2:0]        hdr_speed,
  input  logic              hdr_legacy,
  input  logic              hdr_has_stat,
  input  logic [LANE_W-1:0] hdr_stat,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              in_pair,
  input  logic              in_last,
  output logic [1:0]        ctl_o,
  output logic [LANE_W-1:0] lo_o,
  output logic              lo_oe,
  output logic [LANE_W-1:0] hi_o,
  output logic              hi_oe,
  output logic              hv_o
);
  phase_e            phase;
  speed_e            cur_speed;
  logic              cur_legacy;
  logic [LANE_W-1:0] cur_stat;
  logic [LANE_W-1:0] cur_lo;
  logic [LANE_W-1:0] cur_hi;
  logic              cur_pair;

  rxd_seq i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_owns    (link_owns),
    .hdr_valid    (hdr_valid),
    .hdr_ready    (hdr_ready),
    .hdr_speed    (speed_e'(hdr_speed)),
    .hdr_legacy   (hdr_legacy),
    .hdr_has_stat (hdr_has_stat),
    .hdr_stat     (hdr_stat),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .in_pair      (in_pair),
    .in_last      (in_last),
    .phase        (phase),
    .cur_speed    (cur_speed),
    .cur_legacy   (cur_legacy),
    .cur_stat     (cur_stat),
    .cur_lo       (cur_lo),
    .cur_hi       (cur_hi),
    .cur_pair     (cur_pair)
  );

  rxd_fmt i_fmt (
    .phase      (phase),
    .cur_speed  (cur_speed),
    .cur_legacy (cur_legacy),
    .cur_stat   (cur_stat),
    .cur_lo     (cur_lo),
    .cur_hi     (cur_hi),
    .cur_pair   (cur_pair),
    .link_owns  (link_owns),
    .ctl_o      (ctl_o),
    .lo_o       (lo_o),
    .lo_oe      (lo_oe),
    .hi_o       (hi_o),
    .hi_oe      (hi_oe),
    .hv_o       (hv_o)
  );

  // R2
  dataon_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |=> (ctl_o == 2'b10 && lo_o == 8'hFF && lo_oe));

  // R8
  narrow_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && hdr_speed != 3'd5) |=> !hi_oe);

  // R6
  hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_oe) |-> (ctl_o == 2'b10 && lo_o == 8'hFF));

  // R5
  hv_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hv_o |-> (ctl_o == 2'b10 && hi_oe));
endmodule

// File: tb/test_rx_lane_driver.sv
module test_rx_lane_driver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_owns = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [2:0]  hdr_speed = '0;
  logic        hdr_legacy = 1'b0;
  logic        hdr_has_stat = 1'b0;
  logic [7:0]  hdr_stat = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_pair = 1'b0;
  logic        in_last = 1'b0;
  logic [1:0]  ctl_o;
  logic [7:0]  lo_o;
  logic        lo_oe;
  logic [7:0]  hi_o;
  logic        hi_oe;
  logic        hv_o;

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic [1:0] ctl; logic [7:0] lo; logic hoe; logic [7:0] hi; logic hv;
  } exp_t;
  typedef struct packed { logic [15:0] d; logic pair; logic last; } beat_t;

  exp_t  exp_q[$];
  string tag_q[$];
  beat_t feed_q[$];

  always #4 clk = ~clk;

  rx_lane_driver i_rx_lane_driver (
    .clk(clk), .rst_n(rst_n), .link_owns(link_owns),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_speed(hdr_speed),
    .hdr_legacy(hdr_legacy), .hdr_has_stat(hdr_has_stat), .hdr_stat(hdr_stat),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_pair(in_pair), .in_last(in_last),
    .ctl_o(ctl_o), .lo_o(lo_o), .lo_oe(lo_oe), .hi_o(hi_o), .hi_oe(hi_oe), .hv_o(hv_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] exp_code(input logic [2:0] sp, input bit leg);
    case (sp)
      3'd0: return leg ? 8'h00 : 8'h01;
      3'd1: return leg ? 8'h04 : 8'h05;
      3'd2: return leg ? 8'h08 : 8'h09;
      3'd3: return 8'h0D;
      3'd4: return 8'h0F;
      default: return 8'h0B;
    endcase
  endfunction

  function automatic void push_exp(input logic [1:0] c, input logic [7:0] l,
      input logic ho, input logic [7:0] h, input logic v, input string t);
    exp_t e;
    e.ctl = c; e.lo = l; e.hoe = ho; e.hi = h; e.hv = v;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endfunction

  // feeder: presents the head beat, pops it when consumed
  initial begin
    forever begin
      bit rdy;
      @(negedge clk);
      if (feed_q.size() > 0) begin
        in_valid = 1'b1;
        in_data  = feed_q[0].d;
        in_pair  = feed_q[0].pair;
        in_last  = feed_q[0].last;
      end else begin
        in_valid = 1'b0;
      end
      rdy = in_ready;
      @(posedge clk);
      if (in_valid && rdy) void'(feed_q.pop_front());
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      exp_t  e;
      string t;
      logic [21:0] act, expv;
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act  = {ctl_o, lo_o, hi_oe, hi_oe ? hi_o : 8'h00, hi_oe ? hv_o : 1'b0, lo_oe, hdr_ready};
        expv = {e.ctl, e.lo, e.hoe, e.hoe ? e.hi : 8'h00, e.hoe ? e.hv : 1'b0, 1'b1, 1'b0};
        chk(act == expv, t, "cycle {ctl,lo,hoe,hi,hv,lo_oe,hdr_ready}", 32'(act), 32'(expv));
      end
    end
  end

  task automatic check_rest(input string t);
    @(negedge clk);
    chk({ctl_o, lo_o, lo_oe, hi_oe, hdr_ready} == {2'b00, 8'h00, 1'b1, 1'b0, 1'b1},
        t, "rest {ctl,lo,lo_oe,hi_oe,hdr_ready}",
        32'({ctl_o, lo_o, lo_oe, hi_oe, hdr_ready}), 32'({2'b00, 8'h00, 3'b101}));
  endtask

  task automatic send(input logic [2:0] sp, input bit leg, input bit hs,
                      input logic [7:0] st, input int n, input logic [7:0] base);
    logic [7:0] b[$];
    bit wide;
    int reps;
    beat_t bt;
    wide = (sp == 3'd5);
    reps = (sp >= 3'd4) ? 1 : (16 >> sp);
    for (int i = 0; i < n; i++) b.push_back(base + 8'(i * 37));
    if (wide) begin
      for (int i = 0; i < n; i += 2) begin
        bt.pair = (i + 1 < n);
        bt.d    = {bt.pair ? b[i+1] : 8'h00, b[i]};
        bt.last = (i + 2 >= n);
        feed_q.push_back(bt);
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        // R8: junk upper byte and pair flag must have no effect
        bt.pair = 1'b1; bt.d = {8'hC3, b[i]}; bt.last = (i == n - 1);
        feed_q.push_back(bt);
      end
    end
    @(posedge clk); #1;
    hdr_speed = sp; hdr_legacy = leg; hdr_has_stat = hs; hdr_stat = st;
    hdr_valid = 1'b1;
    @(posedge clk); #1;
    hdr_valid = 1'b0;
    push_exp(2'b10, 8'hFF, wide, 8'h00, 1'b0, wide ? "R6" : "R2");
    if (hs) begin
      push_exp(2'b01, st, wide, 8'h00, 1'b0, "R11");
      push_exp(2'b10, 8'hFF, wide, 8'h00, 1'b0, "R2");
    end
    push_exp(2'b10, exp_code(sp, leg), wide, 8'h00, 1'b0, "R3");
    if (wide) begin
      for (int i = 0; i < n; i += 2) begin
        if (i + 1 < n) push_exp(2'b10, b[i], 1'b1, b[i+1], 1'b1, "R5");
        else           push_exp(2'b10, b[i], 1'b1, 8'h00, 1'b0, "R7");
      end
    end else begin
      for (int i = 0; i < n; i++)
        for (int k = 0; k < reps; k++) push_exp(2'b10, b[i], 1'b0, 8'h00, 1'b0, "R4");
    end
    push_exp(2'b00, 8'h00, wide, 8'h00, 1'b0, "R2");
    while (exp_q.size() > 0) @(posedge clk);
    check_rest("R10");
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_rest("R1");

    send(3'd0, 1'b1, 1'b1, 8'h5A, 2, 8'h11);   // S100 legacy, status
    send(3'd1, 1'b0, 1'b0, 8'h00, 3, 8'h20);   // S200 beta
    send(3'd2, 1'b1, 1'b0, 8'h00, 1, 8'h30);   // S400 legacy
    send(3'd2, 1'b0, 1'b1, 8'hA7, 2, 8'h31);   // S400 beta
    send(3'd3, 1'b1, 1'b0, 8'h00, 3, 8'h40);   // S800, legacy ignored
    send(3'd4, 1'b1, 1'b0, 8'h00, 4, 8'h50);   // S1600, legacy ignored
    send(3'd5, 1'b0, 1'b1, 8'h3C, 6, 8'h60);   // S3200 even
    send(3'd5, 1'b1, 1'b0, 8'h00, 5, 8'h70);   // S3200 odd, legacy ignored
    send(3'd5, 1'b0, 1'b0, 8'h00, 1, 8'h80);   // S3200 single byte

    // R9: bus held by the link at rest
    @(posedge clk); #1;
    link_owns = 1'b1;
    hdr_speed = 3'd5; hdr_valid = 1'b1; hdr_has_stat = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk({lo_oe, hi_oe, hdr_ready} == 3'b000, "R9", "released {lo_oe,hi_oe,hdr_ready}",
          32'({lo_oe, hi_oe, hdr_ready}), 32'h0);
    end
    @(posedge clk); #1;
    hdr_valid = 1'b0;
    @(posedge clk); #1;
    link_owns = 1'b0;
    check_rest("R9");
    send(3'd4, 1'b0, 1'b1, 8'hE1, 2, 8'h90);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule